// File: doc/BRIEF.md
# UART Frame Engine with In-Word Parity

This block sends and receives asynchronous serial frames with a data word of 8 or 9 bits. A frame starts with one low start bit, carries the word least significant bit first, and ends with one high stop bit; the line rests high between frames. When parity is on, the parity bit is not added to the frame. It takes the top position of the configured word, so a frame is always exactly the configured length. On transmit the caller's bit in that position is dropped. On receive that position is cleared before the word is presented.

The word length, parity enable and parity sense are sampled into a configuration register only while the enable input is low. While the engine runs, the settings are frozen. Each direction also copies the frozen settings at the start of every frame, so a frame is never built or checked with mixed settings. A bit lasts `OSR * OS_DIV` clock cycles. The receiver counts oversampling ticks: it checks the start bit at its midpoint and samples every later bit in its middle. A parity mismatch sets a sticky flag, which can raise the interrupt output. A low stop bit sets a separate sticky flag and the word is dropped.

The transmitter has the states TX_IDLE, TX_START, TX_BITS and TX_STOP. It moves TX_IDLE→TX_START when a word is accepted, TX_START→TX_BITS at the end of the start bit, and TX_BITS→TX_STOP after the last data bit. It goes TX_STOP→TX_IDLE at the end of the stop bit. The receiver has the states RX_IDLE, RX_HUNT, RX_BITS and RX_STOP. It moves RX_IDLE→RX_HUNT on a falling line edge. In RX_HUNT it takes RX_HUNT→RX_BITS if the line is still low at mid start bit, and RX_HUNT→RX_IDLE if the line is high there. It moves RX_BITS→RX_STOP after the last data bit and RX_STOP→RX_IDLE at mid stop bit. In both machines, a low enable forces the idle state from any state.

Top module: `uart_frame_engine`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the word least significant bit first, then one high stop bit. Each bit lasts OSR*OS_DIV clock cycles, and txd goes low in the cycle after tx_valid is accepted with tx_ready high.
- R2: cfg_word9=1 selects a 9-bit word and cfg_word9=0 an 8-bit word. In 8-bit mode, tx_data[8] is not sent and rx_data[8] is 0.
- R3: With cfg_par_en=1, the transmitter puts the parity bit in the top word position (bit 8 of 9 or bit 7 of 8). The caller's bit in that position is ignored.
- R4: cfg_par_odd=0 makes the total number of ones in the word even. cfg_par_odd=1 makes it odd.
- R5: With parity on, the receiver presents the word on rx_data with the parity position cleared, as a one-cycle rx_valid pulse.
- R6: If the received parity does not match, pe_flag is set; the word is still delivered. pe_flag stays high until an err_clr pulse.
- R7: irq is high exactly when pe_flag and pe_irq_en are both high.
- R8: Configuration inputs are taken only while en is low. Changes made while en is high have no effect on frames.
- R9: A low stop bit sets fe_flag, cleared by err_clr, and no rx_valid pulse is produced for that frame.
- R10: A low pulse on rxd that is over before mid start bit is rejected. It gives no word and no error, and a later valid frame is still received.
- R11: With en low, txd stays high, tx_ready is low and the receiver ignores rxd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Engine enable; configuration is sampled while low |
| cfg_word9 | input | 1 | 1: 9-bit word, 0: 8-bit word |
| cfg_par_en | input | 1 | Parity in top word position |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| pe_irq_en | input | 1 | Lets pe_flag drive irq |
| err_clr | input | 1 | Clears pe_flag and fe_flag |
| tx_data | input | 9 | Word to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter can accept a word |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 9 | Received word, parity position cleared |
| rx_valid | output | 1 | One-cycle pulse with rx_data |
| pe_flag | output | 1 | Sticky parity error |
| fe_flag | output | 1 | Sticky framing error |
| irq | output | 1 | Parity error interrupt |

## Verification
Transmit results are due on the line at fixed offsets from the accepting edge. txd is low from the next cycle, and bit k is centred OSR*OS_DIV*(k+1)+OSR*OS_DIV/2 cycles after that edge, so the bench samples txd exactly at those centres. A received word appears about half a bit after the stop bit starts, with small jitter from the input synchroniser. The bench therefore watches a window of fourteen bit times and records any rx_valid pulse it sees, so it can check both arrival and absence. The flags rise one cycle after the receive pulse, and irq follows pe_irq_en in the same cycle; the bench reads them a few cycles later.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
    localparam int MAXW = 9;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_BITS, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_BITS, RX_STOP} rx_state_t;

    typedef struct packed {
        logic word9;
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    function automatic int word_len(frame_cfg_t c);
        return c.word9 ? MAXW : MAXW - 1;
    endfunction

    // Word as it goes on the line: upper bits beyond the length zeroed,
    // parity written over the top position when enabled.
    function automatic logic [MAXW-1:0] insert_parity(logic [MAXW-1:0] d, frame_cfg_t c);
        logic [MAXW-1:0] w;
        logic p;
        int n;
        n = word_len(c);
        w = '0;
        p = c.par_odd;
        for (int i = 0; i < MAXW; i++) begin
            if (i < n)     w[i] = d[i];
            if (i < n - 1) p    = p ^ d[i];
        end
        if (c.par_en) w[n-1] = p;
        return w;
    endfunction

    function automatic logic [MAXW-1:0] strip_parity(logic [MAXW-1:0] w, frame_cfg_t c);
        logic [MAXW-1:0] r;
        r = w;
        if (c.par_en) r[word_len(c)-1] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
    parameter int OS_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (OS_DIV <= 1) begin : g_direct
            assign tick = !restart;
        end else begin : g_count
            localparam int CW = $clog2(OS_DIV);
            localparam logic [CW-1:0] LAST = CW'(OS_DIV - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (!rst_n || restart) cnt <= '0;
                else if (cnt == LAST)  cnt <= '0;
                else                   cnt <= cnt + 1'b1;
            end
            assign tick = !restart && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_fe_pkg::*;
#(
    parameter int OS_DIV = 2,
    parameter int OSR    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  frame_cfg_t      cfg,
    input  logic [MAXW-1:0] data,
    input  logic            valid,
    output logic            ready,
    output logic            txd
);
    localparam int OCW = $clog2(OSR);
    localparam int BCW = $clog2(MAXW + 1);
    localparam logic [OCW-1:0] OS_LAST = OCW'(OSR - 1);

    tx_state_t       state, nxt;
    logic [MAXW-1:0] shreg;
    logic [OCW-1:0]  os_cnt;
    logic [BCW-1:0]  bit_cnt, nbits;
    logic            w9, tick, bit_end, idle;

    assign idle    = (state == TX_IDLE);
    assign bit_end = tick && (os_cnt == OS_LAST);
    assign nbits   = w9 ? BCW'(MAXW) : BCW'(MAXW - 1);

    uart_os_tick #(.OS_DIV(OS_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(idle), .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (valid && en) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_BITS;
            TX_BITS:  if (bit_end && bit_cnt == nbits - 1'b1) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
        endcase
        if (!en) nxt = TX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            os_cnt  <= '0;
            bit_cnt <= '0;
            w9      <= 1'b0;
        end else if (idle) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            if (valid && en) begin
                shreg <= insert_parity(data, cfg);
                w9    <= cfg.word9;
            end
        end else if (tick) begin
            os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + 1'b1;
            if (bit_end && state == TX_BITS) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        ready = idle && en;
        unique case (state)
            TX_START: txd = 1'b0;
            TX_BITS:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && valid) |=> !txd);  // R1
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_fe_pkg::*;
#(
    parameter int OS_DIV = 2,
    parameter int OSR    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  frame_cfg_t      cfg,
    input  logic            rxd,
    output logic [MAXW-1:0] data,
    output logic            valid,
    output logic            pe_set,
    output logic            fe_set
);
    localparam int OCW = $clog2(OSR);
    localparam int BCW = $clog2(MAXW + 1);
    localparam logic [OCW-1:0] OS_LAST = OCW'(OSR - 1);
    localparam logic [OCW-1:0] OS_MID  = OCW'(OSR / 2 - 1);

    rx_state_t       state, nxt;
    frame_cfg_t      cfg_l;
    logic [MAXW-1:0] shreg;
    logic [OCW-1:0]  os_cnt;
    logic [BCW-1:0]  bit_cnt, nbits;
    logic            s1, s2, s3, fall, tick, bit_end, mid_end, idle;

    assign idle    = (state == RX_IDLE);
    assign fall    = s3 && !s2;
    assign bit_end = tick && (os_cnt == OS_LAST);
    assign mid_end = tick && (os_cnt == OS_MID);
    assign nbits   = cfg_l.word9 ? BCW'(MAXW) : BCW'(MAXW - 1);

    uart_os_tick #(.OS_DIV(OS_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(idle), .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b111;
        else        {s1, s2, s3} <= {rxd, s1, s2};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (en && fall) nxt = RX_HUNT;
            RX_HUNT:  if (mid_end) nxt = s2 ? RX_IDLE : RX_BITS;
            RX_BITS:  if (bit_end && bit_cnt == nbits - 1'b1) nxt = RX_STOP;
            RX_STOP:  if (bit_end) nxt = RX_IDLE;
        endcase
        if (!en) nxt = RX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_l   <= '0;
            shreg   <= '0;
            os_cnt  <= '0;
            bit_cnt <= '0;
            data    <= '0;
            valid   <= 1'b0;
            pe_set  <= 1'b0;
            fe_set  <= 1'b0;
        end else begin
            valid  <= 1'b0;
            pe_set <= 1'b0;
            fe_set <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    os_cnt  <= '0;
                    bit_cnt <= '0;
                    shreg   <= '0;
                    if (en && fall) cfg_l <= cfg;
                end
                RX_HUNT: if (tick) os_cnt <= (os_cnt == OS_MID) ? '0 : os_cnt + 1'b1;
                RX_BITS: if (tick) begin
                    os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + 1'b1;
                    if (bit_end) begin
                        shreg[bit_cnt] <= s2;
                        bit_cnt        <= bit_cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + 1'b1;
                    if (bit_end && en) begin
                        if (s2) begin
                            valid  <= 1'b1;
                            data   <= strip_parity(shreg, cfg_l);
                            pe_set <= cfg_l.par_en && ((^shreg) != cfg_l.par_odd);
                        end else begin
                            fe_set <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    AST_RX_PAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cfg_l.par_en) |-> !(cfg_l.word9 ? data[8] : data[7]));  // R5
    AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !cfg_l.word9) |-> !data[8]);  // R2
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int OS_DIV = 2,
    parameter int OSR    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cfg_word9,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       pe_irq_en,
    input  logic       err_clr,
    input  logic [8:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       pe_flag,
    output logic       fe_flag,
    output logic       irq
);
    frame_cfg_t cfg_q;
    logic       pe_set, fe_set;

    always_ff @(posedge clk) begin
        if (!rst_n)   cfg_q <= '0;
        else if (!en) cfg_q <= {cfg_word9, cfg_par_en, cfg_par_odd};
    end

    uart_tx #(.OS_DIV(OS_DIV), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg_q),
        .data(tx_data), .valid(tx_valid), .ready(tx_ready), .txd(txd)
    );

    uart_rx #(.OS_DIV(OS_DIV), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg_q), .rxd(rxd),
        .data(rx_data), .valid(rx_valid), .pe_set(pe_set), .fe_set(fe_set)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_flag <= 1'b0;
            fe_flag <= 1'b0;
        end else begin
            pe_flag <= pe_set || (pe_flag && !err_clr);
            fe_flag <= fe_set || (fe_flag && !err_clr);
        end
    end

    assign irq = pe_flag && pe_irq_en;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(cfg_q));  // R8
    AST_PE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_flag && !err_clr) |=> pe_flag);  // R6
    AST_TX_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (txd && !tx_ready));  // R11
    AST_FE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_flag) |-> !rx_valid);  // R9
endmodule

// File: tb/tb_uart_frame_engine.sv
module tb_uart_frame_engine;
    localparam int OS_DIV = 2;
    localparam int OSR    = 16;
    localparam int BIT    = OS_DIV * OSR;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic cfg_word9 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic pe_irq_en = 1'b0, err_clr = 1'b0;
    logic [8:0] tx_data = '0;
    logic tx_valid = 1'b0, tx_ready, txd, rxd;
    logic [8:0] rx_data;
    logic rx_valid, pe_flag, fe_flag, irq;
    logic loop = 1'b1, rxd_drv = 1'b1;
    int checks = 0, fails = 0;
    bit done = 0;

    assign rxd = loop ? txd : rxd_drv;
    always #5 clk = ~clk;

    uart_frame_engine #(.OS_DIV(OS_DIV), .OSR(OSR)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_word9(cfg_word9),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .pe_irq_en(pe_irq_en),
        .err_clr(err_clr), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .pe_flag(pe_flag), .fe_flag(fe_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Line word: low bits copied, top position replaced by parity when enabled.
    function automatic logic [8:0] line_word(logic [8:0] d, bit w9, bit pe, bit odd);
        logic [8:0] mask, w;
        int n;
        n = w9 ? 9 : 8;
        mask = w9 ? 9'h1FF : 9'h0FF;
        w = d & mask;
        if (pe) begin
            w[n-1] = 1'b0;
            w[n-1] = ($countones(w) % 2 == 1) ^ odd;
        end
        return w;
    endfunction

    function automatic logic [8:0] rx_expect(logic [8:0] w, bit w9, bit pe);
        logic [8:0] r;
        r = w & (w9 ? 9'h1FF : 9'h0FF);
        if (pe) r = r & ~(w9 ? 9'h100 : 9'h080);
        return r;
    endfunction

    task automatic set_cfg(input bit w9, input bit pe, input bit odd);
        @(negedge clk); en = 1'b0;
        cfg_word9 = w9; cfg_par_en = pe; cfg_par_odd = odd;
        @(negedge clk); @(negedge clk); en = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_tx(input logic [8:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic wait_rx(output bit got, output logic [8:0] d);
        got = 0; d = '0;
        for (int i = 0; i < 14 * BIT; i++) begin
            @(negedge clk);
            if (rx_valid && !got) begin got = 1; d = rx_data; end
        end
    endtask

    task automatic drive_frame(input logic [8:0] w, input int n, input bit stop);
        @(negedge clk); loop = 1'b0; rxd_drv = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd_drv = w[i];
            repeat (BIT) @(negedge clk);
        end
        rxd_drv = stop;
        repeat (BIT) @(negedge clk);
        rxd_drv = 1'b1;
    endtask

    // Capture a transmitted frame at bit centres: {stop, word, start}.
    task automatic tx_capture(input logic [8:0] d, input int n, output logic [10:0] cap);
        cap = '0;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk); tx_valid = 1'b0;
        repeat (BIT / 2) @(negedge clk);
        cap[0] = txd;
        for (int i = 0; i <= n; i++) begin
            repeat (BIT) @(negedge clk);
            cap[i+1] = txd;
        end
        repeat (BIT) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit got;
        logic [8:0] rd, d, w;
        logic [10:0] cap;
        void'($urandom(32'h1F2E3D4C));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset and disabled state
        check(txd == 1'b1, "R11 txd idle", txd, 1);
        check(tx_ready == 1'b0, "R11 ready off", tx_ready, 0);
        check(rx_valid == 1'b0, "R11 no rx", rx_valid, 0);
        check(pe_flag == 1'b0 && fe_flag == 1'b0, "R6 flags reset", {pe_flag, fe_flag}, 0);
        check(irq == 1'b0, "R7 irq reset", irq, 0);

        // R1 R3 R4: 8-bit even, bit 7 of input overwritten
        set_cfg(0, 1, 0);
        tx_capture(9'h037, 8, cap);
        w = line_word(9'h037, 0, 1, 0);
        check(cap[0] == 1'b0 && cap[9] == 1'b1, "R1 start/stop", {cap[9], cap[0]}, 2'b10);
        check(cap[8:1] == w[7:0], "R3 R4 even parity 8b", cap[8:1], w[7:0]);
        // R2 R4: 9-bit odd
        set_cfg(1, 1, 1);
        tx_capture(9'h0FF, 9, cap);
        w = line_word(9'h0FF, 1, 1, 1);
        check(cap[0] == 1'b0 && cap[10] == 1'b1, "R1 start/stop 9b", {cap[10], cap[0]}, 2'b10);
        check(cap[9:1] == w, "R2 R4 odd parity 9b", cap[9:1], w);

        // Random loopback, R2 R3 R4 R5
        for (int k = 0; k < 24; k++) begin
            bit rw9, rpe, rodd;
            rw9 = 1'($urandom % 2); rpe = 1'($urandom % 2); rodd = 1'($urandom % 2);
            d = 9'($urandom % 512);
            set_cfg(rw9, rpe, rodd);
            @(negedge clk); loop = 1'b1;
            fork
                send_tx(d);
                wait_rx(got, rd);
            join
            check(got, "R5 loopback word seen", got, 1);
            check(rd == rx_expect(line_word(d, rw9, rpe, rodd), rw9, rpe),
                  "R2 R3 R5 loopback data", rd, rx_expect(line_word(d, rw9, rpe, rodd), rw9, rpe));
            check(pe_flag == 1'b0, "R4 no parity error", pe_flag, 0);
        end

        // R2: 8-bit, no parity, tx_data[8] dropped
        set_cfg(0, 0, 0);
        fork send_tx(9'h1FF); wait_rx(got, rd); join
        check(got && rd == 9'h0FF, "R2 8b drop bit8", rd, 9'h0FF);

        // R6 R7: parity mismatch
        set_cfg(0, 1, 0);
        pe_irq_en = 1'b1;
        fork drive_frame(9'h001, 8, 1'b1); wait_rx(got, rd); join
        check(got && rd == 9'h001, "R6 word delivered on error", rd, 9'h001);
        check(pe_flag == 1'b1, "R6 pe set", pe_flag, 1);
        check(irq == 1'b1, "R7 irq on", irq, 1);
        @(negedge clk); pe_irq_en = 1'b0;
        #1 check(irq == 1'b0, "R7 irq gated", irq, 0);
        repeat (40) @(negedge clk);
        check(pe_flag == 1'b1, "R6 pe sticky", pe_flag, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
        check(pe_flag == 1'b0, "R6 pe cleared", pe_flag, 0);

        // R9: framing error
        set_cfg(0, 0, 0);
        fork drive_frame(9'h055, 8, 1'b0); wait_rx(got, rd); join
        check(!got, "R9 no word on bad stop", got, 0);
        check(fe_flag == 1'b1, "R9 fe set", fe_flag, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
        check(fe_flag == 1'b0, "R9 fe cleared", fe_flag, 0);

        // R10: short glitch rejected, then good frame
        @(negedge clk); loop = 1'b0; rxd_drv = 1'b0;
        repeat (6) @(negedge clk); rxd_drv = 1'b1;
        wait_rx(got, rd);
        check(!got && !fe_flag, "R10 glitch rejected", {got, fe_flag}, 0);
        fork drive_frame(9'h0A6, 8, 1'b1); wait_rx(got, rd); join
        check(got && rd == 9'h0A6, "R10 frame after glitch", rd, 9'h0A6);

        // R8: change while enabled has no effect
        set_cfg(0, 0, 0);
        @(negedge clk); cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        loop = 1'b1;
        fork send_tx(9'h0FF); wait_rx(got, rd); join
        check(got && rd == 9'h0FF, "R8 config locked", rd, 9'h0FF);

        // R11: disabled engine ignores rxd
        @(negedge clk); en = 1'b0;
        fork drive_frame(9'h03C, 8, 1'b1); wait_rx(got, rd); join
        check(!got, "R11 rx ignored", got, 0);
        check(txd == 1'b1 && tx_ready == 1'b0, "R11 tx quiet", {txd, tx_ready}, 2'b10);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule